// File: doc/BRIEF.md
# Stream Descriptor Buffer with Watermarks

This block sits at the write end of a shared, multi-stream pipeline. It buffers the descriptors of runnable instruction streams and returns them, oldest first, to the fetch end. Each descriptor carries four fields: the stream's program counter, the base of its short-address environment, the owning process number and a status word. The block does three more things. It flags a fault once too many streams are waiting. It reports when the population has fallen low enough for held streams to resume. It can discard every stream of a killed process in one short operation.

An external interrupt is turned into exactly one new descriptor. Its program counter comes from the interrupt's code pointer, and its environment base comes from the interrupt's data-space pointer. The handler later retires through a merge with a zero argument, so nothing else is left queued for it. Interrupts win over ordinary insertions in the same cycle. A purge takes one busy cycle, during which insertions, interrupts and removals are all held off.

Top module: `strm_desc_buf`

## Requirements
- R1: After reset the buffer is empty: `occupancy` is 0, `out_valid` is 0, `hwm_fault` and `hwm_hit` are 0, `below_lwm` is 1 and `in_ready` is 1.
- R2: Descriptors leave on `out_*` in the order they were accepted, with all four fields unchanged. A descriptor is removed in a cycle where `out_valid` and `out_ready` are both high.
- R3: When `occupancy` equals DEPTH, `in_ready` and `irq_take` are low, nothing is accepted and `occupancy` stays at DEPTH.
- R4: Outside a purge, `occupancy` changes as follows at each edge: it rises by one for an accepted insertion, falls by one for a removal, and is unchanged when both or neither happen.
- R5: `hwm_fault` is high exactly while `occupancy` >= HI_MARK. `hwm_hit` is high for exactly one cycle, in the cycle after `hwm_fault` rises.
- R6: `below_lwm` is high exactly while `occupancy` < LO_MARK.
- R7: `irq_take` is high when `irq_req` is high, the buffer is not full and no purge is running. Each take adds one descriptor with PC = `irq_code`, prefix = `irq_space`, process = `irq_pid` and status = IRQ_STATUS (default 4'h1).
- R8: While `irq_req` is high, `in_ready` is low, so an interrupt always wins over an insertion in the same cycle.
- R9: If `kill_req` is sampled high while idle, `kill_busy` is high for exactly the next cycle. At the end of that cycle, every stored descriptor whose process field equals the sampled `kill_pid` is gone. The survivors keep their relative order, and `occupancy` equals the number of survivors.
- R10: While `kill_busy` is high, `in_ready`, `irq_take` and `out_valid` are low.
- R11: `out_valid` is high when `occupancy` is nonzero and no purge is running. While `out_valid` is high and `out_ready` is low, the `out_*` fields hold their values into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Insertion request |
| in_ready | output | 1 | Insertion accepted this cycle if in_valid |
| in_pc | input | PC_W | Program counter of inserted stream |
| in_pfx | input | PFX_W | Environment base of inserted stream |
| in_pid | input | PID_W | Process number of inserted stream |
| in_stat | input | ST_W | Status word of inserted stream |
| irq_req | input | 1 | External interrupt pending |
| irq_take | output | 1 | Interrupt converted to a descriptor this cycle |
| irq_code | input | PC_W | Handler code pointer |
| irq_space | input | PFX_W | Handler environment pointer |
| irq_pid | input | PID_W | Process number for the handler stream |
| out_valid | output | 1 | Head descriptor available |
| out_ready | input | 1 | Fetch end takes the head |
| out_pc | output | PC_W | Head program counter |
| out_pfx | output | PFX_W | Head environment base |
| out_pid | output | PID_W | Head process number |
| out_stat | output | ST_W | Head status word |
| kill_req | input | 1 | Purge request |
| kill_pid | input | PID_W | Process number to purge |
| kill_busy | output | 1 | Purge in progress |
| occupancy | output | $clog2(DEPTH+1) | Stored descriptor count |
| hwm_fault | output | 1 | Count at or above high-water mark |
| hwm_hit | output | 1 | One-cycle pulse after hwm_fault rises |
| below_lwm | output | 1 | Count below low-water mark |

## Verification
A corrupted slot or a wrong compaction rank does not show until that descriptor reaches the head. From then on it appears on the `out_*` fields when it is popped, so the scoreboard finds it only after every older entry has drained. A count that is off by one shows at once on `occupancy` and on the watermark flags, and a few cycles later as `in_ready` dropping early or late near the full boundary. A purge that removes the wrong process shows after the busy cycle, first as a wrong survivor count and then as wrong entries in the drained sequence.

// File: rtl/sdb_pkg.sv
package sdb_pkg;

    typedef enum logic {
        SDB_RUN   = 1'b0,
        SDB_PURGE = 1'b1
    } sdb_mode_e;

    function automatic int sdb_cnt_w(input int depth);
        return $clog2(depth + 1);
    endfunction

    function automatic int sdb_idx_w(input int depth);
        return (depth > 1) ? $clog2(depth) : 1;
    endfunction

endpackage

// File: rtl/sdb_intake.sv
module sdb_intake #(
    parameter int PC_W  = 16,
    parameter int PFX_W = 8,
    parameter int PID_W = 4,
    parameter int ST_W  = 4,
    parameter logic [ST_W-1:0] IRQ_STATUS = 4'h1,
    localparam int DW = PC_W + PFX_W + PID_W + ST_W
) (
    input  logic             in_valid,
    input  logic [DW-1:0]    in_desc,
    input  logic             irq_req,
    input  logic [PC_W-1:0]  irq_code,
    input  logic [PFX_W-1:0] irq_space,
    input  logic [PID_W-1:0] irq_pid,
    input  logic             room,
    input  logic             busy,
    output logic             in_ready,
    output logic             irq_take,
    output logic             push,
    output logic [DW-1:0]    push_desc
);

    logic          open_gate;
    logic [DW-1:0] irq_desc;

    always_comb begin
        open_gate = room && !busy;
        irq_take  = irq_req && open_gate;
        in_ready  = open_gate && !irq_req;
        push      = irq_take || (in_valid && in_ready);
        irq_desc  = {irq_code, irq_space, irq_pid, IRQ_STATUS};
        push_desc = irq_take ? irq_desc : in_desc;
    end

endmodule

// File: rtl/sdb_store.sv
module sdb_store #(
    parameter int DW      = 32,
    parameter int DEPTH   = 8,
    parameter int PID_LSB = 4,
    parameter int PID_W   = 4,
    localparam int CW = sdb_pkg::sdb_cnt_w(DEPTH),
    localparam int AW = sdb_pkg::sdb_idx_w(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [DW-1:0]    push_desc,
    input  logic             pop,
    input  logic             purge_go,
    input  logic [PID_W-1:0] purge_pid,
    output logic [DW-1:0]    head,
    output logic [CW-1:0]    count
);

    typedef struct packed {
        logic [DEPTH-1:0][DW-1:0] ent;
        logic [CW-1:0]            cnt;
    } store_t;

    store_t cur_q, nxt_d;

    logic [DEPTH-1:0]         keep;
    logic [DEPTH-1:0][CW-1:0] rank;
    logic [CW-1:0]            survivors;

    // survivor mask and compaction rank of each slot
    always_comb begin
        logic [CW-1:0] acc;
        acc = '0;
        for (int i = 0; i < DEPTH; i++) begin
            keep[i] = (CW'(i) < cur_q.cnt) &&
                      (cur_q.ent[i][PID_LSB +: PID_W] != purge_pid);
            rank[i] = acc;
            if (keep[i]) acc = acc + CW'(1);
        end
        survivors = acc;
    end

    always_comb begin
        logic [CW-1:0] wr_at;
        nxt_d = cur_q;
        wr_at = cur_q.cnt;
        if (purge_go) begin
            nxt_d.ent = '0;
            for (int i = 0; i < DEPTH; i++) begin
                if (keep[i]) nxt_d.ent[rank[i][AW-1:0]] = cur_q.ent[i];
            end
            nxt_d.cnt = survivors;
        end else begin
            if (pop) begin
                for (int j = 0; j < DEPTH - 1; j++) begin
                    nxt_d.ent[j] = cur_q.ent[j+1];
                end
                nxt_d.ent[DEPTH-1] = '0;
                nxt_d.cnt = cur_q.cnt - CW'(1);
                wr_at     = cur_q.cnt - CW'(1);
            end
            if (push) begin
                nxt_d.ent[wr_at[AW-1:0]] = push_desc;
                nxt_d.cnt = pop ? cur_q.cnt : cur_q.cnt + CW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign head  = cur_q.ent[0];
    assign count = cur_q.cnt;

    // R9: compaction never grows the store
    p_purge_shrinks_r9: assert property (@(posedge clk) disable iff (!rst_n)
        purge_go |=> (cur_q.cnt <= $past(cur_q.cnt)));

    // R11: a removal only happens when something is stored
    p_pop_nonempty_r11: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (cur_q.cnt != '0));

    // R3: an insertion never lands in a full store
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop) |-> (cur_q.cnt < CW'(DEPTH)));

endmodule

// File: rtl/sdb_level.sv
module sdb_level #(
    parameter int DEPTH   = 8,
    parameter int HI_MARK = 6,
    parameter int LO_MARK = 3,
    localparam int CW = sdb_pkg::sdb_cnt_w(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] cnt,
    output logic          at_high,
    output logic          below_low,
    output logic          hit
);

    typedef struct packed {
        logic prev;
        logic hit;
    } lvl_t;

    lvl_t lvl_q, lvl_d;

    always_comb begin
        at_high   = (cnt >= CW'(HI_MARK));
        below_low = (cnt < CW'(LO_MARK));
        lvl_d.prev = at_high;
        lvl_d.hit  = at_high && !lvl_q.prev;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_q <= '0;
        end else begin
            lvl_q <= lvl_d;
        end
    end

    assign hit = lvl_q.hit;

    // R5: the crossing pulse lasts one cycle
    p_hit_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> !hit);

    // R5: every upward crossing produces the pulse
    p_hit_follows_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(at_high) |=> hit);

endmodule

// File: rtl/strm_desc_buf.sv
module strm_desc_buf #(
    parameter int PC_W    = 16,
    parameter int PFX_W   = 8,
    parameter int PID_W   = 4,
    parameter int ST_W    = 4,
    parameter int DEPTH   = 8,
    parameter int HI_MARK = 6,
    parameter int LO_MARK = 3,
    parameter logic [ST_W-1:0] IRQ_STATUS = 4'h1,
    localparam int DW = PC_W + PFX_W + PID_W + ST_W,
    localparam int CW = sdb_pkg::sdb_cnt_w(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [PC_W-1:0]  in_pc,
    input  logic [PFX_W-1:0] in_pfx,
    input  logic [PID_W-1:0] in_pid,
    input  logic [ST_W-1:0]  in_stat,
    input  logic             irq_req,
    output logic             irq_take,
    input  logic [PC_W-1:0]  irq_code,
    input  logic [PFX_W-1:0] irq_space,
    input  logic [PID_W-1:0] irq_pid,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [PC_W-1:0]  out_pc,
    output logic [PFX_W-1:0] out_pfx,
    output logic [PID_W-1:0] out_pid,
    output logic [ST_W-1:0]  out_stat,
    input  logic             kill_req,
    input  logic [PID_W-1:0] kill_pid,
    output logic             kill_busy,
    output logic [CW-1:0]    occupancy,
    output logic             hwm_fault,
    output logic             hwm_hit,
    output logic             below_lwm
);
    import sdb_pkg::*;

    typedef struct packed {
        sdb_mode_e        mode;
        logic [PID_W-1:0] kpid;
    } ctl_t;

    ctl_t ctl_q, ctl_d;

    logic          room;
    logic          push;
    logic          pop;
    logic [DW-1:0] push_desc;
    logic [DW-1:0] head;
    logic [CW-1:0] cnt;

    always_comb begin
        ctl_d = ctl_q;
        case (ctl_q.mode)
            SDB_RUN: begin
                if (kill_req) begin
                    ctl_d.mode = SDB_PURGE;
                    ctl_d.kpid = kill_pid;
                end
            end
            default: ctl_d.mode = SDB_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '{mode: SDB_RUN, kpid: '0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign kill_busy = (ctl_q.mode == SDB_PURGE);
    assign room      = (cnt != CW'(DEPTH));
    assign out_valid = (cnt != '0) && !kill_busy;
    assign pop       = out_valid && out_ready;

    sdb_intake #(
        .PC_W(PC_W), .PFX_W(PFX_W), .PID_W(PID_W), .ST_W(ST_W),
        .IRQ_STATUS(IRQ_STATUS)
    ) u_intake (
        .in_valid  (in_valid),
        .in_desc   ({in_pc, in_pfx, in_pid, in_stat}),
        .irq_req   (irq_req),
        .irq_code  (irq_code),
        .irq_space (irq_space),
        .irq_pid   (irq_pid),
        .room      (room),
        .busy      (kill_busy),
        .in_ready  (in_ready),
        .irq_take  (irq_take),
        .push      (push),
        .push_desc (push_desc)
    );

    sdb_store #(
        .DW(DW), .DEPTH(DEPTH), .PID_LSB(ST_W), .PID_W(PID_W)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_desc (push_desc),
        .pop       (pop),
        .purge_go  (kill_busy),
        .purge_pid (ctl_q.kpid),
        .head      (head),
        .count     (cnt)
    );

    sdb_level #(
        .DEPTH(DEPTH), .HI_MARK(HI_MARK), .LO_MARK(LO_MARK)
    ) u_level (
        .clk       (clk),
        .rst_n     (rst_n),
        .cnt       (cnt),
        .at_high   (hwm_fault),
        .below_low (below_lwm),
        .hit       (hwm_hit)
    );

    assign {out_pc, out_pfx, out_pid, out_stat} = head;
    assign occupancy = cnt;

    // R8: an interrupt request masks ordinary insertion
    p_irq_priority_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> !in_ready);

    // R10: nothing moves in or out while a purge runs
    p_purge_blocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
        kill_busy |-> (!in_ready && !irq_take && !out_valid));

    // R9: the purge occupies exactly one cycle
    p_purge_one_cycle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        kill_busy |=> !kill_busy);

    // R4: outside a purge the count moves by at most one
    p_count_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !kill_busy |=> ((int'(occupancy) == int'($past(occupancy))) ||
                        (int'(occupancy) == int'($past(occupancy)) + 1) ||
                        (int'(occupancy) + 1 == int'($past(occupancy)))));

    // R11: a stalled head stays put
    p_head_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> ($stable(out_pc) && $stable(out_pfx) &&
                                        $stable(out_pid) && $stable(out_stat)));

    // R3: a full buffer accepts nothing
    p_full_closed_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (occupancy == CW'(DEPTH)) |-> (!in_ready && !irq_take));

endmodule

// File: tb/strm_desc_buf_bench.sv
module strm_desc_buf_bench;

    localparam int PERIOD  = 10;
    localparam int PC_W    = 16;
    localparam int PFX_W   = 8;
    localparam int PID_W   = 4;
    localparam int ST_W    = 4;
    localparam int DEPTH   = 8;
    localparam int HI_MARK = 6;
    localparam int LO_MARK = 3;
    localparam logic [ST_W-1:0] IRQ_ST = 4'h1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [PC_W-1:0]  pc;
        logic [PFX_W-1:0] pfx;
        logic [PID_W-1:0] pid;
        logic [ST_W-1:0]  st;
    } bd_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0, in_ready;
    logic [PC_W-1:0] in_pc = '0;
    logic [PFX_W-1:0] in_pfx = '0;
    logic [PID_W-1:0] in_pid = '0;
    logic [ST_W-1:0] in_stat = '0;
    logic irq_req = 1'b0, irq_take;
    logic [PC_W-1:0] irq_code = '0;
    logic [PFX_W-1:0] irq_space = '0;
    logic [PID_W-1:0] irq_pid = '0;
    logic out_valid, out_ready = 1'b0;
    logic [PC_W-1:0] out_pc;
    logic [PFX_W-1:0] out_pfx;
    logic [PID_W-1:0] out_pid;
    logic [ST_W-1:0] out_stat;
    logic kill_req = 1'b0;
    logic [PID_W-1:0] kill_pid = '0;
    logic kill_busy;
    logic [CW-1:0] occupancy;
    logic hwm_fault, hwm_hit, below_lwm;

    int n_chk = 0;
    int n_bad = 0;
    bd_t exp_q[$];

    always #(PERIOD/2) clk = ~clk;

    strm_desc_buf #(
        .PC_W(PC_W), .PFX_W(PFX_W), .PID_W(PID_W), .ST_W(ST_W),
        .DEPTH(DEPTH), .HI_MARK(HI_MARK), .LO_MARK(LO_MARK), .IRQ_STATUS(IRQ_ST)
    ) u_strm_desc_buf (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready),
        .in_pc(in_pc), .in_pfx(in_pfx), .in_pid(in_pid), .in_stat(in_stat),
        .irq_req(irq_req), .irq_take(irq_take),
        .irq_code(irq_code), .irq_space(irq_space), .irq_pid(irq_pid),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_pc(out_pc), .out_pfx(out_pfx), .out_pid(out_pid), .out_stat(out_stat),
        .kill_req(kill_req), .kill_pid(kill_pid), .kill_busy(kill_busy),
        .occupancy(occupancy), .hwm_fault(hwm_fault), .hwm_hit(hwm_hit),
        .below_lwm(below_lwm)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic bd_t mk(input int k);
        bd_t d;
        d.pc  = PC_W'(16'h100 + k);
        d.pfx = PFX_W'(8'h20 + k);
        d.pid = (k % 2 == 0) ? PID_W'(1) : PID_W'(2);
        d.st  = ST_W'(k % 16);
        return d;
    endfunction

    task automatic drive_in(input bd_t d);
        in_pc = d.pc; in_pfx = d.pfx; in_pid = d.pid; in_stat = d.st;
    endtask

    // step to 1 time unit after the next rising edge
    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    // monitor: compare every removed head against the scoreboard (R2, R7, R9)
    always @(negedge clk) begin
        if (rst_n && out_valid && out_ready) begin
            if (exp_q.size() == 0) begin
                n_chk++; n_bad++;
                $display("FAIL R2: actual %0h expected nothing queued",
                         {out_pc, out_pfx, out_pid, out_stat});
            end else begin
                check("R2 order/fields", {out_pc, out_pfx, out_pid, out_stat}, exp_q[0]);
                void'(exp_q.pop_front());
            end
        end
    end

    initial begin
        #(PERIOD * 20000);
        n_bad++; n_chk++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        bd_t d;
        bd_t kept[$];
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        #3;
        // R1 reset state
        check("R1 occupancy", 64'(occupancy), 0);
        check("R1 out_valid", 64'(out_valid), 0);
        check("R1 hwm_fault", 64'(hwm_fault), 0);
        check("R1 hwm_hit", 64'(hwm_hit), 0);
        check("R1 below_lwm", 64'(below_lwm), 1);
        check("R1 in_ready", 64'(in_ready), 1);
        tick();

        // two entries, then stall the head (R11)
        for (int k = 20; k < 22; k++) begin
            d = mk(k); drive_in(d); in_valid = 1'b1;
            #3; check("R4 ready", 64'(in_ready), 1);
            if (in_ready) exp_q.push_back(d);
            tick();
        end
        in_valid = 1'b0;
        #3;
        check("R11 valid", 64'(out_valid), 1);
        check("R11 head", {out_pc, out_pfx, out_pid, out_stat}, exp_q[0]);
        tick(); #3;
        check("R11 head held", {out_pc, out_pfx, out_pid, out_stat}, exp_q[0]);
        out_ready = 1'b1;
        tick(); tick(); out_ready = 1'b0;
        #3; check("R4 drained", 64'(occupancy), 0);
        tick();

        // fill to DEPTH, checking watermarks every cycle (R4, R5, R6)
        for (int k = 0; k < DEPTH; k++) begin
            d = mk(k); drive_in(d); in_valid = 1'b1;
            #3;
            check("R4 count", 64'(occupancy), 64'(k));
            check("R5 fault", 64'(hwm_fault), 64'(k >= HI_MARK));
            check("R5 hit", 64'(hwm_hit), 64'(k == HI_MARK + 1));
            check("R6 low", 64'(below_lwm), 64'(k < LO_MARK));
            if (in_ready) exp_q.push_back(d);
            tick();
        end
        d = mk(9); drive_in(d);
        #3;
        check("R3 full count", 64'(occupancy), 64'(DEPTH));
        check("R3 ready low", 64'(in_ready), 0);
        check("R5 hit cleared", 64'(hwm_hit), 0);
        irq_req = 1'b1;
        #1; check("R7 no take when full", 64'(irq_take), 0);
        tick(); irq_req = 1'b0;
        #3; check("R3 count held", 64'(occupancy), 64'(DEPTH));
        in_valid = 1'b0;
        tick();

        // remove one, leaving 7
        out_ready = 1'b1; tick(); out_ready = 1'b0;
        #3; check("R4 after pop", 64'(occupancy), 64'(DEPTH - 1));
        tick();

        // purge process 1 (R9, R10)
        kill_req = 1'b1; kill_pid = PID_W'(1);
        kept.delete();
        foreach (exp_q[i]) if (exp_q[i].pid != PID_W'(1)) kept.push_back(exp_q[i]);
        exp_q = kept;
        tick(); kill_req = 1'b0;
        in_valid = 1'b1; d = mk(30); drive_in(d); irq_req = 1'b1;
        #3;
        check("R9 busy", 64'(kill_busy), 1);
        check("R10 in_ready", 64'(in_ready), 0);
        check("R10 irq_take", 64'(irq_take), 0);
        check("R10 out_valid", 64'(out_valid), 0);
        in_valid = 1'b0; irq_req = 1'b0;
        tick(); #3;
        check("R9 busy ends", 64'(kill_busy), 0);
        check("R9 survivors", 64'(occupancy), 64'(exp_q.size()));
        check("R6 low after purge", 64'(below_lwm), 64'(exp_q.size() < LO_MARK));
        tick();

        // interrupt wins over insertion (R7, R8)
        d = mk(40); drive_in(d); in_valid = 1'b1;
        irq_req = 1'b1; irq_code = 16'hBEEF; irq_space = 8'h5A; irq_pid = 4'h7;
        #3;
        check("R8 ready masked", 64'(in_ready), 0);
        check("R7 take", 64'(irq_take), 1);
        if (irq_take) exp_q.push_back('{pc: 16'hBEEF, pfx: 8'h5A, pid: 4'h7, st: IRQ_ST});
        tick(); irq_req = 1'b0;
        #3; check("R8 ready back", 64'(in_ready), 1);
        if (in_ready) exp_q.push_back(d);
        tick(); in_valid = 1'b0;
        #3; check("R4 count", 64'(occupancy), 64'(exp_q.size()));
        tick();

        // simultaneous insert and remove (R4)
        d = mk(50); drive_in(d); in_valid = 1'b1; out_ready = 1'b1;
        #3; if (in_ready) exp_q.push_back(d);
        tick(); in_valid = 1'b0; out_ready = 1'b0;
        #3; check("R4 push+pop", 64'(occupancy), 64'(exp_q.size()));
        tick();

        // drain everything
        out_ready = 1'b1;
        repeat (DEPTH + 2) tick();
        out_ready = 1'b0;
        #3;
        check("R2 all drained", 64'(exp_q.size()), 0);
        check("R4 empty", 64'(occupancy), 0);
        check("R11 valid low when empty", 64'(out_valid), 0);
        tick();

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule